// File: doc/BRIEF.md
# Ethernet Pause Capability Resolver

This block decides, at the end of auto-negotiation, whether the MAC should act on received pause frames and whether it may send its own. It takes the local advertisement word, the link partner's ability word and a one-cycle negotiation-complete strobe. From these it works out the best link mode that both ends support. If that mode is full duplex, it applies the symmetric and asymmetric pause rules. The two results are registered and hold as status flags.

The flags keep their value until another completion strobe loads new values, or until a restart pulse or reset clears them. The negotiation protocol, the management access path and the MAC's own pause-frame handling sit outside this block.

Top module: `pause_resolver`

## Requirements
- R1: After reset, pause_rx_o and pause_tx_o are both 0.
- R2: With a full-duplex common mode, when bit 10 (symmetric pause) is set in both words, both pause_rx_o and pause_tx_o become 1.
- R3: With a full-duplex common mode, local bit10=0, local bit11=1 (asymmetric), partner bit10=1 and partner bit11=1 give pause_tx_o=1 and pause_rx_o=0.
- R4: With a full-duplex common mode, local bit10=1, local bit11=1, partner bit10=0 and partner bit11=1 give pause_rx_o=1 and pause_tx_o=0.
- R5: Every other combination of the four pause bits gives both outputs 0.
- R6: The common mode is the first set bit of (local[9:5] & partner[9:5]) in this order: bit 8 (100 full), bit 9 (100 four-pair), bit 7 (100 half), bit 6 (10 full), bit 5 (10 half). Only bit 8 or bit 6 counts as full duplex. A half-duplex winner forces both outputs to 0.
- R7: When the two technology fields share no bit, both outputs are 0.
- R8: The outputs take their new value on the first clock edge that samples an_done_i high. They stay unchanged while an_done_i and an_restart_i are low, whatever the input words do.
- R9: an_restart_i clears both outputs on the next edge and wins over a simultaneous an_done_i.
- R10: Bits 15:12 and 4:0 of both words have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| local_adv_i | input | 16 | Local advertisement word |
| partner_adv_i | input | 16 | Link partner ability word |
| an_done_i | input | 1 | Negotiation-complete strobe, loads the flags |
| an_restart_i | input | 1 | Negotiation restart, clears the flags |
| pause_rx_o | output | 1 | MAC should honour received pause frames |
| pause_tx_o | output | 1 | MAC may transmit pause frames |

## Verification
The only state is the registered flag pair, so a wrong selection of the common mode or of the pause rule shows up one edge after the completion strobe. That makes every load an immediate observation point. A fault in the hold or clear path only appears later: as a flag that drifts while the strobe is idle, or that survives a restart. The bench therefore checks the flags again after the input words have changed without a strobe, and after restart pulses, including one that collides with a strobe.

// File: rtl/pause_res_pkg.sv
package pause_res_pkg;
  typedef enum logic [2:0] {
    HCD_NONE     = 3'd0,
    HCD_100TX_FD = 3'd1,
    HCD_100T4    = 3'd2,
    HCD_100TX_HD = 3'd3,
    HCD_10T_FD   = 3'd4,
    HCD_10T_HD   = 3'd5
  } hcd_e;

  typedef struct packed {
    logic rx;
    logic tx;
  } pause_dir_t;
endpackage

// File: rtl/hcd_select.sv
module hcd_select
  import pause_res_pkg::*;
#(
  parameter int unsigned TECH_N = 5
) (
  input  logic [TECH_N-1:0] local_tech_i,
  input  logic [TECH_N-1:0] partner_tech_i,
  output logic [TECH_N-1:0] sel_onehot_o,
  output hcd_e              hcd_o,
  output logic              full_duplex_o
);
  // rank k -> bit index in the technology field (rank 0 wins)
  localparam int unsigned RANK_BIT [5] = '{3, 4, 2, 1, 0};
  localparam logic [4:0]  FD_RANKS     = 5'b01001;

  logic [TECH_N-1:0] common;
  logic [TECH_N-1:0] ranked;
  logic [TECH_N:0]   seen;

  assign common  = local_tech_i & partner_tech_i;
  assign seen[0] = 1'b0;

  for (genvar k = 0; k < TECH_N; k++) begin : g_rank
    assign ranked[k]       = common[RANK_BIT[k]];
    assign sel_onehot_o[k] = ranked[k] & ~seen[k];
    assign seen[k+1]       = seen[k] | ranked[k];
  end

  assign full_duplex_o = |(sel_onehot_o & FD_RANKS[TECH_N-1:0]);

  always_comb begin
    hcd_o = HCD_NONE;
    unique case (sel_onehot_o)
      5'b00001: hcd_o = HCD_100TX_FD;
      5'b00010: hcd_o = HCD_100T4;
      5'b00100: hcd_o = HCD_100TX_HD;
      5'b01000: hcd_o = HCD_10T_FD;
      5'b10000: hcd_o = HCD_10T_HD;
      default:  hcd_o = HCD_NONE;
    endcase
  end

  always_comb begin
    if (common == '0) assert_none_R7: assert (sel_onehot_o == '0 && !full_duplex_o);
  end
endmodule

// File: rtl/pause_rules.sv
module pause_rules
  import pause_res_pkg::*;
(
  input  logic       loc_sym_i,
  input  logic       loc_asm_i,
  input  logic       par_sym_i,
  input  logic       par_asm_i,
  output pause_dir_t dir_o
);
  always_comb begin
    dir_o = '{rx: 1'b0, tx: 1'b0};
    casez ({loc_sym_i, loc_asm_i, par_sym_i, par_asm_i})
      4'b1?1?: dir_o = '{rx: 1'b1, tx: 1'b1};
      4'b0111: dir_o = '{rx: 1'b0, tx: 1'b1};
      4'b1101: dir_o = '{rx: 1'b1, tx: 1'b0};
      default: dir_o = '{rx: 1'b0, tx: 1'b0};
    endcase
  end

  always_comb begin
    if (!loc_asm_i && !loc_sym_i) assert_no_cap_R5: assert (dir_o == '0);
  end
endmodule

// File: rtl/pause_flag_reg.sv
module pause_flag_reg
  import pause_res_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       clear_i,
  input  logic       full_duplex_i,
  input  pause_dir_t dir_i,
  output logic       rx_o,
  output logic       tx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_o <= 1'b0;
      tx_o <= 1'b0;
    end else if (clear_i) begin
      rx_o <= 1'b0;
      tx_o <= 1'b0;
    end else if (load_i) begin
      rx_o <= dir_i.rx & full_duplex_i;
      tx_o <= dir_i.tx & full_duplex_i;
    end
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clear_i) |=> ($stable(rx_o) && $stable(tx_o)));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!rx_o && !tx_o));

  assert_hd_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i && !full_duplex_i) |=> (!rx_o && !tx_o));

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i && full_duplex_i && dir_i.rx && dir_i.tx) |=> (rx_o && tx_o));
endmodule

// File: rtl/pause_resolver.sv
module pause_resolver
  import pause_res_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned SYM_BIT  = 10,
  parameter int unsigned ASM_BIT  = 11,
  parameter int unsigned TECH_LSB = 5,
  parameter int unsigned TECH_N   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] local_adv_i,
  input  logic [WORD_W-1:0] partner_adv_i,
  input  logic              an_done_i,
  input  logic              an_restart_i,
  output logic              pause_rx_o,
  output logic              pause_tx_o
);
  localparam int unsigned TECH_MSB = TECH_LSB + TECH_N - 1;

  logic [TECH_N-1:0] sel_onehot;
  hcd_e              hcd;
  logic              full_duplex;
  pause_dir_t        dir;

  hcd_select #(.TECH_N(TECH_N)) u_hcd (
    .local_tech_i  (local_adv_i[TECH_MSB:TECH_LSB]),
    .partner_tech_i(partner_adv_i[TECH_MSB:TECH_LSB]),
    .sel_onehot_o  (sel_onehot),
    .hcd_o         (hcd),
    .full_duplex_o (full_duplex)
  );

  pause_rules u_rules (
    .loc_sym_i(local_adv_i[SYM_BIT]),
    .loc_asm_i(local_adv_i[ASM_BIT]),
    .par_sym_i(partner_adv_i[SYM_BIT]),
    .par_asm_i(partner_adv_i[ASM_BIT]),
    .dir_o    (dir)
  );

  pause_flag_reg u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (an_done_i),
    .clear_i      (an_restart_i),
    .full_duplex_i(full_duplex),
    .dir_i        (dir),
    .rx_o         (pause_rx_o),
    .tx_o         (pause_tx_o)
  );

  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_onehot) && ((hcd == HCD_NONE) == (sel_onehot == '0)));

  assert_fd_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_duplex |-> (hcd == HCD_100TX_FD || hcd == HCD_10T_FD));

  assert_tx_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_done_i && !an_restart_i && full_duplex &&
     !local_adv_i[SYM_BIT] && local_adv_i[ASM_BIT] &&
     partner_adv_i[SYM_BIT] && partner_adv_i[ASM_BIT]) |=> (pause_tx_o && !pause_rx_o));

  assert_rx_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_done_i && !an_restart_i && full_duplex &&
     local_adv_i[SYM_BIT] && local_adv_i[ASM_BIT] &&
     !partner_adv_i[SYM_BIT] && partner_adv_i[ASM_BIT]) |=> (pause_rx_o && !pause_tx_o));
endmodule

// File: tb/pause_resolver_bench.sv
`timescale 1ns/1ps
module pause_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] loc = '0;
  logic [15:0] par = '0;
  logic        done = 1'b0;
  logic        restart = 1'b0;
  logic        prx, ptx;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 1'b0;
  logic [1:0]  model = 2'b00;

  always #10 clk = ~clk;

  pause_resolver u_pause_resolver (
    .clk_i(clk), .rst_ni(rst_n), .local_adv_i(loc), .partner_adv_i(par),
    .an_done_i(done), .an_restart_i(restart), .pause_rx_o(prx), .pause_tx_o(ptx)
  );

  // {rx, tx}
  function automatic logic [1:0] expect_dir(logic [15:0] l, logic [15:0] p);
    logic [4:0] c;
    logic fd;
    logic [3:0] b;
    c = l[9:5] & p[9:5];
    if (c[3])      fd = 1'b1;
    else if (c[4]) fd = 1'b0;
    else if (c[2]) fd = 1'b0;
    else if (c[1]) fd = 1'b1;
    else           fd = 1'b0;
    if (!fd) return 2'b00;
    b = {l[10], l[11], p[10], p[11]};
    if (l[10] && p[10]) return 2'b11;
    if (b == 4'b0111) return 2'b01;
    if (b == 4'b1101) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(string req, logic [1:0] exp);
    n_checks++;
    if ({prx, ptx} !== exp) begin
      n_errors++;
      $display("FAIL %s: rx/tx actual=%b expected=%b (loc=%h par=%h)", req, {prx, ptx}, exp, loc, par);
    end
  endtask

  // strobe with given words; check one edge later
  task automatic load(logic [15:0] l, logic [15:0] p, logic rs, string req);
    @(negedge clk);
    loc = l; par = p; done = 1'b1; restart = rs;
    @(negedge clk);
    done = 1'b0; restart = 1'b0;
    model = rs ? 2'b00 : expect_dir(l, p);
    check(req, model);
  endtask

  localparam logic [15:0] TX_FD = 16'h0100;
  localparam logic [15:0] ALL_T = 16'h03E0;

  initial begin
    void'($urandom(32'd2024));
    #35;
    check("R1", 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'b00);

    load(TX_FD | 16'h0400, TX_FD | 16'h0400, 1'b0, "R2");
    load(TX_FD | 16'h0800, TX_FD | 16'h0C00, 1'b0, "R3");
    load(TX_FD | 16'h0C00, TX_FD | 16'h0800, 1'b0, "R4");
    load(TX_FD | 16'h0800, TX_FD | 16'h0800, 1'b0, "R5");
    load(TX_FD | 16'h0400, TX_FD | 16'h0800, 1'b0, "R5");
    load(TX_FD | 16'h0C00, TX_FD | 16'h0000, 1'b0, "R5");
    // T4 beats 10 full -> half duplex winner
    load(16'h0640, 16'h0640, 1'b0, "R6");
    load(16'h0440, 16'h0440, 1'b0, "R6");
    load(16'h04C0, 16'h04C0, 1'b0, "R6");
    load(16'h0420 | ALL_T, 16'h0420 | 16'h0100, 1'b0, "R6");
    load(16'h0420, 16'h0420, 1'b0, "R6");
    load(16'h0500, 16'h04E0, 1'b0, "R7");
    load(16'hF41F | TX_FD, 16'h041F | TX_FD, 1'b0, "R10");
    load(16'h0400 | TX_FD, 16'hF400 | TX_FD, 1'b0, "R10");

    // hold: words change, no strobe
    @(negedge clk);
    loc = 16'h0000; par = 16'h0000;
    repeat (3) @(negedge clk);
    check("R8", model);

    // restart clears
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0; model = 2'b00;
    check("R9", 2'b00);
    load(TX_FD | 16'h0400, TX_FD | 16'h0400, 1'b0, "R2");
    load(TX_FD | 16'h0400, TX_FD | 16'h0400, 1'b1, "R9");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] l, p;
      l = 16'($urandom);
      p = 16'($urandom);
      if (i % 3 == 0) begin l[9:5] = 5'b00001 << (i % 5); p[9:5] = l[9:5] | 5'($urandom); end
      load(l, p, ($urandom % 16) == 0, "R2");
      if (i % 50 == 7) begin
        @(negedge clk);
        loc = 16'($urandom); par = 16'($urandom);
        repeat (2) @(negedge clk);
        check("R8", model);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule